// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Engine

This block produces the status flags of a FIFO whose writer and reader run on unrelated clocks. It keeps the write and read pointers and exports the memory addresses. Each pointer crosses to the other clock domain as a Gray code through a chain of synchronizing flops. The last flop of each chain is the flag register itself. The write domain reports whether a location is free and whether the FIFO is nearly full. The read domain reports whether data can be taken and whether the FIFO is nearly empty.

The block runs in one of two read-side timing modes, chosen while the read reset is held. In standard mode the read flag means "not empty", and a read request fetches from memory. In fall-through mode the block moves the first word into an output register without being asked. The read flag then means "the output register holds a valid word", and a read request consumes that word. A word in the output register has already left the memory, so it is not part of the fill level. Both near-threshold offsets are captured from input pins during reset and are held from then on.

Top module: `dcfifo_flags`

## Requirements
- R1: While the resets are held, the read flag is 0, the almost-empty output is 0, the almost-full output is 1, the space flag is 0 and both addresses are 0. The space flag rises on the first write-clock edge after the write reset is released.
- R2: In standard mode (mode pin 0), after a write into an empty FIFO, the read flag is still 0 after the first following read-clock edge and is 1 after the second.
- R3: In fall-through mode (mode pin 1), after a write into an empty FIFO, the read flag is 1 only after the third following read-clock edge. The load strobe is high in the cycle before that edge, and the read address steps on that edge.
- R4: The space flag is 0 while DEPTH words are stored. A write request in that state is not accepted, and the write address does not move.
- R5: After a read frees a location in a full FIFO, the space flag is still 0 after the first following write-clock edge and is 1 after the second.
- R6: The almost-empty output is 0 when the FIFO holds X words or fewer and 1 when it holds X+1 or more, where X is the captured empty offset. After the write that reaches X+1, it rises on the second read-clock edge. A read that drops the level to X or below clears it on the read edge itself.
- R7: The almost-full output is 0 when the FIFO holds DEPTH−Y words or more and 1 when it holds DEPTH−Y−1 or fewer, where Y is the captured full offset. A write clears it on the write edge itself. After the read that brings the level to DEPTH−Y−1, it rises on the second write-clock edge.
- R8: In fall-through mode, the word held in the output register does not count toward the fill level that the almost-empty output compares against.
- R9: The mode pin and both offset pins affect behaviour only while their domain's reset is held. Changing them afterwards has no effect.
- R10: In standard mode, a read of the last word clears the read flag on that read edge. A read request while the flag is 0 raises no load strobe and leaves the read address unchanged.
- R11: Write and read addresses each advance by one per accepted operation and wrap from DEPTH−1 to 0.
- R12: In fall-through mode, consuming the output word while memory still holds words reloads the output register on the same edge, so the read flag stays 1. The consumption that empties both clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side reset, active low; also captures the full offset |
| wr_req | input | 1 | Write attempt this cycle |
| af_offset | input | ADDR_W+1 | Almost-full offset Y, sampled during write reset |
| wr_addr | output | ADDR_W | Memory address of the next write |
| wr_accept | output | 1 | The write attempt is taken at the coming edge |
| wr_space | output | 1 | 1 when at least one location is free (full / input-ready) |
| af_n | output | 1 | 0 when the FIFO is almost full |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side reset, active low; also captures mode and empty offset |
| rd_req | input | 1 | Read (standard) or consume (fall-through) request |
| fwft_sel | input | 1 | 1 selects fall-through mode, sampled during read reset |
| ae_offset | input | ADDR_W+1 | Almost-empty offset X, sampled during read reset |
| rd_addr | output | ADDR_W | Memory address of the next word to leave memory |
| rd_load | output | 1 | Output register takes memory[rd_addr] at the coming edge |
| rd_avail | output | 1 | 1 when data can be read (not-empty / output-ready) |
| ae_n | output | 1 | 0 when the FIFO is almost empty |

## Verification
In fall-through mode, the consumption of the output word and the reload from memory can fall on the same read-clock edge. The bench sets this up by queueing several words and then holding the consume request high across consecutive edges. It judges the result by the read flag, which must not dip, and by the read address, which must step once per edge until memory is drained. A second coincidence is the fall-through load edge, where the almost-empty output must fall at the same moment the read flag rises. The bench checks both outputs on that single edge.

// File: rtl/dcff_pkg.sv
`timescale 1ns/100ps
package dcff_pkg;

    // Read-side timing mode, captured during read reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    // Total synchronizer depth including the flag register stage.
    localparam int unsigned SYNC_DEPTH_DEFAULT = 2;

endpackage

// File: rtl/dcff_sync.sv
`timescale 1ns/100ps
// Plain flop chain for a Gray-coded pointer. The consumer's own state
// register supplies the final stage, so this holds STAGES flops.
module dcff_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcff_gray2bin.sv
`timescale 1ns/100ps
// Gray to binary: each bit is the XOR of all Gray bits at or above it.
module dcff_gray2bin #(
    parameter int unsigned W = 5
) (
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    assign bin_o[W-1] = gray_i[W-1];
    for (genvar i = 0; i < W - 1; i++) begin : g_bit
        assign bin_o[i] = ^gray_i[W-1:i];
    end
endmodule

// File: rtl/dcff_wr_side.sv
`timescale 1ns/100ps
// Write-domain pointer, space flag (R4, R5) and almost-full flag (R7).
module dcff_wr_side #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_req_i,
    input  logic [ADDR_W:0]   af_off_i,
    input  logic [ADDR_W:0]   rd_gray_i,
    output logic [ADDR_W:0]   wr_gray_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_accept_o,
    output logic              wr_space_o,
    output logic              af_n_o
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH = {1'b1, {ADDR_W{1'b0}}};
    localparam int unsigned CHAIN = SYNC_STAGES - 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] gray;
        logic             space;
        logic             af_n;
    } wr_state_t;

    localparam wr_state_t WR_RESET = '{ptr: '0, gray: '0, space: 1'b0, af_n: 1'b1};

    wr_state_t        st_d, st_q;
    logic [PTR_W-1:0] af_off_q;
    logic [PTR_W-1:0] rd_gray_tap;
    logic [PTR_W-1:0] rd_bin_tap;
    logic [PTR_W-1:0] level_d;
    logic [PTR_W-1:0] af_limit;
    logic             accept;

    dcff_sync #(.W(PTR_W), .STAGES(CHAIN)) u_sync (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .async_i (rd_gray_i),
        .sync_o  (rd_gray_tap)
    );

    dcff_gray2bin #(.W(PTR_W)) u_g2b (
        .gray_i (rd_gray_tap),
        .bin_o  (rd_bin_tap)
    );

    // R9: offset captured only while reset is held
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            af_off_q <= af_off_i;
        end
    end

    assign af_limit = DEPTH - af_off_q;

    always_comb begin
        st_d        = st_q;
        accept      = wr_req_i & st_q.space;
        st_d.ptr    = st_q.ptr + PTR_W'(accept);
        st_d.gray   = st_d.ptr ^ (st_d.ptr >> 1);
        // flag registers act as the last synchronizer stage
        level_d     = st_d.ptr - rd_bin_tap;
        st_d.space  = (level_d != DEPTH);
        st_d.af_n   = (level_d < af_limit);
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            st_q <= WR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_gray_o   = st_q.gray;
    assign wr_addr_o   = st_q.ptr[ADDR_W-1:0];
    assign wr_accept_o = accept;
    assign wr_space_o  = st_q.space;
    assign af_n_o      = st_q.af_n;
endmodule

// File: rtl/dcff_rd_side.sv
`timescale 1ns/100ps
// Read-domain pointer, read flag in both modes (R2, R3, R10, R12),
// output-register load control and almost-empty flag (R6, R8).
module dcff_rd_side
    import dcff_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_req_i,
    input  logic              mode_i,
    input  logic [ADDR_W:0]   ae_off_i,
    input  logic [ADDR_W:0]   wr_gray_i,
    output logic [ADDR_W:0]   rd_gray_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_load_o,
    output logic              rd_avail_o,
    output logic              ae_n_o
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned CHAIN = SYNC_STAGES - 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] gray;
        logic [PTR_W-1:0] wbin;   // final sync stage of the write pointer
        logic             avail;
        logic             ae_n;
    } rd_state_t;

    localparam rd_state_t RD_RESET = '{ptr: '0, gray: '0, wbin: '0, avail: 1'b0, ae_n: 1'b0};

    rd_state_t        st_d, st_q;
    rd_mode_e         mode_q;
    logic [PTR_W-1:0] ae_off_q;
    logic [PTR_W-1:0] wr_gray_tap;
    logic [PTR_W-1:0] wr_bin_tap;
    logic [PTR_W-1:0] fill_d;
    logic             load;

    dcff_sync #(.W(PTR_W), .STAGES(CHAIN)) u_sync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .async_i (wr_gray_i),
        .sync_o  (wr_gray_tap)
    );

    dcff_gray2bin #(.W(PTR_W)) u_g2b (
        .gray_i (wr_gray_tap),
        .bin_o  (wr_bin_tap)
    );

    // R9: mode and offset captured only while reset is held
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            mode_q   <= rd_mode_e'(mode_i);
            ae_off_q <= ae_off_i;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.wbin = wr_bin_tap;
        if (mode_q == MODE_FWFT) begin
            // fall-through: refill the output register from the fully
            // synchronized pointer, one cycle after the standard flag would rise
            load       = (st_q.wbin != st_q.ptr) && (!st_q.avail || rd_req_i);
            st_d.ptr   = st_q.ptr + PTR_W'(load);
            st_d.avail = load || (st_q.avail && !rd_req_i);
        end else begin
            load       = rd_req_i && st_q.avail;
            st_d.ptr   = st_q.ptr + PTR_W'(load);
            st_d.avail = (st_d.wbin != st_d.ptr);
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        // words in memory only; an output-register word is already counted out
        fill_d    = st_d.wbin - st_d.ptr;
        st_d.ae_n = (fill_d > ae_off_q);
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            st_q <= RD_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_gray_o  = st_q.gray;
    assign rd_addr_o  = st_q.ptr[ADDR_W-1:0];
    assign rd_load_o  = load;
    assign rd_avail_o = st_q.avail;
    assign ae_n_o     = st_q.ae_n;
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/100ps
// Top level: joins the two clock domains through Gray pointers.
module dcfifo_flags #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned SYNC_STAGES = dcff_pkg::SYNC_DEPTH_DEFAULT
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W:0]   af_offset,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_accept,
    output logic              wr_space,
    output logic              af_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_req,
    input  logic              fwft_sel,
    input  logic [ADDR_W:0]   ae_offset,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_load,
    output logic              rd_avail,
    output logic              ae_n
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_gray;
    logic [PTR_W-1:0] rd_gray;

    dcff_wr_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_req_i    (wr_req),
        .af_off_i    (af_offset),
        .rd_gray_i   (rd_gray),
        .wr_gray_o   (wr_gray),
        .wr_addr_o   (wr_addr),
        .wr_accept_o (wr_accept),
        .wr_space_o  (wr_space),
        .af_n_o      (af_n)
    );

    dcff_rd_side #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .rd_req_i   (rd_req),
        .mode_i     (fwft_sel),
        .ae_off_i   (ae_offset),
        .wr_gray_i  (wr_gray),
        .rd_gray_o  (rd_gray),
        .rd_addr_o  (rd_addr),
        .rd_load_o  (rd_load),
        .rd_avail_o (rd_avail),
        .ae_n_o     (ae_n)
    );
endmodule

// File: rtl/dcfifo_flags_chk.sv
`timescale 1ns/100ps
module dcfifo_flags_chk #(
    parameter int unsigned ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_accept,
    input logic              wr_space,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_req,
    input logic              fwft_sel,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_load,
    input logic              rd_avail
);
    // checker's own record of the mode seen during read reset
    logic mode_seen;
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            mode_seen <= fwft_sel;
        end
    end

    a_r4_wr_addr_hold_when_full: assert property (
        @(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_space |=> $stable(wr_addr));

    a_r11_wr_addr_step: assert property (
        @(posedge wr_clk) disable iff (!wr_rst_n)
        wr_accept |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    a_r11_rd_addr_step: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        rd_load |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    a_r10_rd_addr_hold_without_load: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_load |=> $stable(rd_addr));

    a_r3_fwft_load_sets_avail: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        (mode_seen && rd_load) |=> rd_avail);

    a_r12_fwft_avail_held: assert property (
        @(posedge rd_clk) disable iff (!rd_rst_n)
        (mode_seen && rd_avail && !rd_req) |=> rd_avail);
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .wr_addr   (wr_addr),
    .wr_accept (wr_accept),
    .wr_space  (wr_space),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_req    (rd_req),
    .fwft_sel  (fwft_sel),
    .rd_addr   (rd_addr),
    .rd_load   (rd_load),
    .rd_avail  (rd_avail)
);

// File: tb/dcfifo_flags_bench.sv
`timescale 1ns/100ps
module dcfifo_flags_bench;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_req = 1'b0;
    logic              rd_req = 1'b0;
    logic              fwft_sel = 1'b0;
    logic [ADDR_W:0]   af_offset = '0;
    logic [ADDR_W:0]   ae_offset = '0;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_accept, wr_space, af_n;
    logic              rd_load, rd_avail, ae_n;

    int n_checks = 0;
    int n_errs   = 0;

    dcfifo_flags #(.ADDR_W(ADDR_W)) u_dcfifo_flags (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .af_offset(af_offset),
        .wr_addr(wr_addr), .wr_accept(wr_accept), .wr_space(wr_space), .af_n(af_n),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_req(rd_req), .fwft_sel(fwft_sel),
        .ae_offset(ae_offset), .rd_addr(rd_addr), .rd_load(rd_load),
        .rd_avail(rd_avail), .ae_n(ae_n)
    );

    // 200 MHz write clock; read clock 7 ns with an offset so edges never meet
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #0.3;
        forever #3.5 rd_clk = ~rd_clk;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        #1000000;
        n_errs++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(posedge rd_clk);
        #1;
    endtask

    task automatic wait_wr(input int n);
        repeat (n) @(posedge wr_clk);
        #1;
    endtask

    task automatic settle();
        repeat (6) @(posedge rd_clk);
        repeat (6) @(posedge wr_clk);
        #1;
    endtask

    task automatic write_n(input int n);
        @(negedge wr_clk);
        wr_req = 1'b1;
        repeat (n) @(posedge wr_clk);
        #0.1;
        wr_req = 1'b0;
    endtask

    task automatic read_n(input int n);
        @(negedge rd_clk);
        rd_req = 1'b1;
        repeat (n) @(posedge rd_clk);
        #0.1;
        rd_req = 1'b0;
    endtask

    task automatic do_reset(input logic mode, input int x, input int y);
        wr_req = 1'b0;
        rd_req = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        fwft_sel = mode;
        ae_offset = (ADDR_W+1)'(x);
        af_offset = (ADDR_W+1)'(y);
        repeat (3) @(posedge rd_clk);
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        fwft_sel = 1'b0;
        ae_offset = 2;
        af_offset = 2;
        repeat (3) @(posedge rd_clk);
        #1;
        chk("R1", "rd_avail in reset", rd_avail, 0);
        chk("R1", "ae_n in reset", ae_n, 0);
        chk("R1", "af_n in reset", af_n, 1);
        chk("R1", "wr_space in reset", wr_space, 0);
        chk("R1", "wr_addr in reset", wr_addr, 0);
        chk("R1", "rd_addr in reset", rd_addr, 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        #0.5;
        chk("R1", "wr_space before first edge", wr_space, 0);
        wait_wr(1);
        chk("R1", "wr_space after first edge", wr_space, 1);
        @(negedge rd_clk) rd_rst_n = 1'b1;
        settle();
        chk("R1", "rd_avail idle", rd_avail, 0);
    endtask

    task automatic t_std_latency();
        do_reset(1'b0, 2, 2);
        write_n(1);
        wait_rd(1);
        chk("R2", "rd_avail after edge 1", rd_avail, 0);
        wait_rd(1);
        chk("R2", "rd_avail after edge 2", rd_avail, 1);
        chk("R10", "rd_addr before read", rd_addr, 0);
        read_n(1);
        #1;
        chk("R10", "rd_avail after last read", rd_avail, 0);
        chk("R11", "rd_addr after read", rd_addr, 1);
        @(negedge rd_clk);
        rd_req = 1'b1;
        #0.5;
        chk("R10", "rd_load on empty read", rd_load, 0);
        @(posedge rd_clk);
        #0.1;
        rd_req = 1'b0;
        #1;
        chk("R10", "rd_addr after empty read", rd_addr, 1);
        chk("R10", "rd_avail after empty read", rd_avail, 0);
    endtask

    task automatic t_fwft();
        do_reset(1'b1, 0, 2);
        write_n(1);
        wait_rd(1);
        chk("R3", "ready after edge 1", rd_avail, 0);
        wait_rd(1);
        chk("R3", "ready after edge 2", rd_avail, 0);
        chk("R3", "load before edge 3", rd_load, 1);
        chk("R6", "ae_n with one word in memory", ae_n, 1);
        wait_rd(1);
        chk("R3", "ready after edge 3", rd_avail, 1);
        chk("R3", "rd_addr after load", rd_addr, 1);
        chk("R8", "ae_n with word in output reg", ae_n, 0);
        write_n(3);
        settle();
        chk("R12", "ready with queue", rd_avail, 1);
        chk("R8", "ae_n three in memory", ae_n, 1);
        read_n(3);
        #1;
        chk("R12", "ready during stream", rd_avail, 1);
        chk("R12", "rd_addr after stream", rd_addr, 4);
        chk("R8", "ae_n memory drained", ae_n, 0);
        read_n(1);
        #1;
        chk("R12", "ready after final consume", rd_avail, 0);
        chk("R12", "rd_addr unchanged", rd_addr, 4);
    endtask

    task automatic t_full();
        do_reset(1'b0, 2, 3);
        write_n(DEPTH - 3 - 1);
        settle();
        chk("R7", "af_n at DEPTH-Y-1", af_n, 1);
        chk("R11", "wr_addr after 12", wr_addr, DEPTH - 4);
        write_n(1);
        #1;
        chk("R7", "af_n at DEPTH-Y", af_n, 0);
        write_n(3);
        #1;
        chk("R4", "wr_space when full", wr_space, 0);
        chk("R11", "wr_addr wrapped", wr_addr, 0);
        @(negedge wr_clk);
        wr_req = 1'b1;
        #0.5;
        chk("R4", "wr_accept when full", wr_accept, 0);
        @(posedge wr_clk);
        #0.1;
        wr_req = 1'b0;
        #1;
        chk("R4", "wr_addr after blocked write", wr_addr, 0);
        read_n(1);
        wait_wr(1);
        chk("R5", "wr_space after wr edge 1", wr_space, 0);
        wait_wr(1);
        chk("R5", "wr_space after wr edge 2", wr_space, 1);
        read_n(3);
        wait_wr(1);
        chk("R7", "af_n after wr edge 1", af_n, 0);
        wait_wr(1);
        chk("R7", "af_n after wr edge 2", af_n, 1);
    endtask

    task automatic t_ae();
        do_reset(1'b0, 2, 2);
        write_n(2);
        settle();
        chk("R6", "ae_n at X words", ae_n, 0);
        write_n(1);
        wait_rd(1);
        chk("R6", "ae_n after rd edge 1", ae_n, 0);
        wait_rd(1);
        chk("R6", "ae_n after rd edge 2", ae_n, 1);
        read_n(1);
        #1;
        chk("R6", "ae_n after read to X", ae_n, 0);
    endtask

    task automatic t_cfg();
        do_reset(1'b0, 2, 2);
        fwft_sel = 1'b1;
        ae_offset = 0;
        af_offset = 10;
        write_n(1);
        settle();
        chk("R9", "ae_n keeps X=2", ae_n, 0);
        chk("R9", "rd_addr no auto load", rd_addr, 0);
        chk("R9", "rd_avail standard", rd_avail, 1);
        write_n(5);
        settle();
        chk("R9", "af_n keeps Y=2", af_n, 1);
        chk("R9", "ae_n six words", ae_n, 1);
    endtask

    initial begin
        t_reset();
        t_std_latency();
        t_fwft();
        t_full();
        t_ae();
        t_cfg();
        finish_run();
    end
endmodule